// File: doc/BRIEF.md
# Load-Use and Branch Stall Tracker

This block is the timing bookkeeper for an in-order core that issues either one instruction or a parallel pair per group. Each instruction is presented for one clock with `valid_i` high. It carries its source register numbers with per-source valid flags, a load flag with a destination register, a branch flag with a taken flag, a base cycle cost, and markers for the first and last instruction of its group. The block does not execute anything. It works out how many stall cycles each instruction suffers and what the group as a whole costs.

A load records its destination in a pending mask. After every instruction, the pending mask becomes the active mask that the next instruction's sources are checked against. The pending mask is cleared when a group starts, so a load hazard reaches the rest of its own group and the first instruction that follows. A pair costs the larger of its two members' costs, not their sum. Five saturating counters keep running totals: group cycles, load stall cycles, branch stall cycles, taken branches and untaken branches.

Top module: `stall_tracker`

## Requirements
- R1: After reset, all five counters read zero and `grp_valid_o` is low.
- R2: A valid source whose register bit is set in the active mask adds 2 cycles to the instruction's load stall, and 2 more if the other checked source also hits. The load stall of every valid instruction is added to `load_stall_o`.
- R3: When an instruction with `first_i` high is taken, the pending mask restarts from empty. The pending mask then gains the load destination if there is one. After every valid instruction, the active mask equals this pending mask. As a result, a load is visible to the later instructions of its own group and to the next instruction only.
- R4: When `is_load_i` or `is_branch_i` is high, source B is not checked, whatever `src_b_vld_i` says.
- R5: A source whose valid flag is low causes no check.
- R6: A branch with `taken_i` high adds 2 stall cycles and increments `taken_o`. A branch with `taken_i` low adds no stall and increments `untaken_o`. `taken_i` has no effect when `is_branch_i` is low.
- R7: An instruction costs its base cycles plus its load stall plus its branch stall. One cycle after the last instruction of a group is taken, `grp_valid_o` is high for exactly that cycle and `grp_cycles_o` holds the group cost.
- R8: For a pair, the group cost is the larger of the first and second instruction's costs.
- R9: `cycles_o` grows by the group cost only on the cycle that takes a last instruction.
- R10: Every counter saturates at its all-ones value instead of wrapping.
- R11: `clear_i` zeroes all five counters on the next edge and overrides any increment in the same cycle. Masks and group state still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous counter clear |
| valid_i | input | 1 | Instruction present this cycle |
| first_i | input | 1 | First instruction of its group |
| last_i | input | 1 | Last instruction of its group |
| src_a_i | input | REG_W | Source A register number |
| src_a_vld_i | input | 1 | Source A is used |
| src_b_i | input | REG_W | Source B register number |
| src_b_vld_i | input | 1 | Source B is used |
| is_load_i | input | 1 | Instruction is a load |
| load_dst_i | input | REG_W | Load destination register |
| is_branch_i | input | 1 | Instruction is a branch |
| taken_i | input | 1 | Branch is taken |
| base_cyc_i | input | BASE_W | Base cycle cost |
| grp_valid_o | output | 1 | Group cost valid pulse |
| grp_cycles_o | output | BASE_W+2 | Effective cost of the finished group |
| cycles_o | output | CNT_W | Total group cycles |
| load_stall_o | output | CNT_W | Total load stall cycles |
| branch_stall_o | output | CNT_W | Total branch stall cycles |
| taken_o | output | CNT_W | Taken branch count |
| untaken_o | output | CNT_W | Untaken branch count |

## Verification
The bench checks the short lifetime of a load hazard. A design that kept the active mask across more than one instruction would charge stalls to unrelated later reads. A design that did not pass a pair's first load to its second member would miss a stall. Loads and branches with a valid, hitting source B must cost nothing extra; a design that checked that source would add 2 cycles. Pairs are driven with the larger cost in either position, so a design that summed the members or always took one side reports the wrong group cost. A narrow second instance is pushed past its all-ones value, and `clear_i` is raised together with `valid_i`, which exposes wrapping counters and the wrong priority between clear and increment.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int STALL_PEN = 2;
  localparam int N_CNT     = 5;

  typedef enum logic [2:0] {
    CNT_CYC = 3'd0,
    CNT_LDS = 3'd1,
    CNT_BRS = 3'd2,
    CNT_TKN = 3'd3,
    CNT_UNT = 3'd4
  } cnt_idx_e;
endpackage

// File: rtl/stall_hazard.sv
module stall_hazard #(
  parameter int REG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             first_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic             src_a_vld_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic             src_b_vld_i,
  input  logic             one_src_i,
  input  logic             is_load_i,
  input  logic [REG_W-1:0] load_dst_i,
  output logic [1:0]       hit_cnt_o
);
  localparam int NREG = 1 << REG_W;

  logic [NREG-1:0] pend_q, act_q, pend_d, dst_oh;
  logic            hit_a, hit_b;

  always_comb begin
    dst_oh = '0;
    if (is_load_i) dst_oh[load_dst_i] = 1'b1;
    pend_d = (first_i ? '0 : pend_q) | dst_oh;
  end

  assign hit_a     = src_a_vld_i & act_q[src_a_i];
  assign hit_b     = src_b_vld_i & ~one_src_i & act_q[src_b_i];
  assign hit_cnt_o = {1'b0, hit_a} + {1'b0, hit_b};

  // active mask follows pending after every instruction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else if (valid_i) begin
      pend_q <= pend_d;
      act_q  <= pend_d;
    end
  end
endmodule

// File: rtl/stall_group.sv
module stall_group #(
  parameter int TOT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [TOT_W-1:0] cost_i,
  output logic [TOT_W-1:0] grp_max_o,
  output logic             grp_valid_o,
  output logic [TOT_W-1:0] grp_cycles_o
);
  logic [TOT_W-1:0] held_q, held_base;

  always_comb begin
    held_base = first_i ? '0 : held_q;
    grp_max_o = (held_base > cost_i) ? held_base : cost_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q       <= '0;
      grp_valid_o  <= 1'b0;
      grp_cycles_o <= '0;
    end else begin
      grp_valid_o <= valid_i & last_i;
      if (valid_i) begin
        if (last_i) grp_cycles_o <= grp_max_o;
        else        held_q       <= grp_max_o;
      end
    end
  end
endmodule

// File: rtl/stall_sat_ctr.sv
module stall_sat_ctr #(
  parameter int CNT_W = 32,
  parameter int INC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] MAX_S = SUM_W'({CNT_W{1'b1}});

  logic [SUM_W-1:0] sum;

  assign sum = SUM_W'(cnt_o) + SUM_W'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= (sum > MAX_S) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/stall_tracker.sv
module stall_tracker
  import stall_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int BASE_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [REG_W-1:0]  src_a_i,
  input  logic              src_a_vld_i,
  input  logic [REG_W-1:0]  src_b_i,
  input  logic              src_b_vld_i,
  input  logic              is_load_i,
  input  logic [REG_W-1:0]  load_dst_i,
  input  logic              is_branch_i,
  input  logic              taken_i,
  input  logic [BASE_W-1:0] base_cyc_i,
  output logic              grp_valid_o,
  output logic [BASE_W+1:0] grp_cycles_o,
  output logic [CNT_W-1:0]  cycles_o,
  output logic [CNT_W-1:0]  load_stall_o,
  output logic [CNT_W-1:0]  branch_stall_o,
  output logic [CNT_W-1:0]  taken_o,
  output logic [CNT_W-1:0]  untaken_o
);
  localparam int TOT_W = BASE_W + 2;

  logic [1:0]       hit_cnt;
  logic [TOT_W-1:0] ld_stall, br_stall, cost, grp_max;
  logic             br_taken, br_untaken;

  logic [N_CNT-1:0]            cnt_en;
  logic [N_CNT-1:0][TOT_W-1:0] cnt_inc;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_val;

  stall_hazard #(.REG_W(REG_W)) u_hazard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .first_i    (first_i),
    .src_a_i    (src_a_i),
    .src_a_vld_i(src_a_vld_i),
    .src_b_i    (src_b_i),
    .src_b_vld_i(src_b_vld_i),
    .one_src_i  (is_load_i | is_branch_i),
    .is_load_i  (is_load_i),
    .load_dst_i (load_dst_i),
    .hit_cnt_o  (hit_cnt)
  );

  assign br_taken   = is_branch_i & taken_i;
  assign br_untaken = is_branch_i & ~taken_i;
  assign ld_stall   = TOT_W'(hit_cnt) * TOT_W'(STALL_PEN);
  assign br_stall   = br_taken ? TOT_W'(STALL_PEN) : '0;
  assign cost       = TOT_W'(base_cyc_i) + ld_stall + br_stall;

  stall_group #(.TOT_W(TOT_W)) u_group (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .first_i     (first_i),
    .last_i      (last_i),
    .cost_i      (cost),
    .grp_max_o   (grp_max),
    .grp_valid_o (grp_valid_o),
    .grp_cycles_o(grp_cycles_o)
  );

  always_comb begin
    cnt_en           = '0;
    cnt_inc          = '0;
    cnt_en[CNT_CYC]  = valid_i & last_i;
    cnt_inc[CNT_CYC] = grp_max;
    cnt_en[CNT_LDS]  = valid_i;
    cnt_inc[CNT_LDS] = ld_stall;
    cnt_en[CNT_BRS]  = valid_i;
    cnt_inc[CNT_BRS] = br_stall;
    cnt_en[CNT_TKN]  = valid_i & br_taken;
    cnt_inc[CNT_TKN] = TOT_W'(1);
    cnt_en[CNT_UNT]  = valid_i & br_untaken;
    cnt_inc[CNT_UNT] = TOT_W'(1);
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    stall_sat_ctr #(.CNT_W(CNT_W), .INC_W(TOT_W)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clear_i),
      .en_i  (cnt_en[g]),
      .inc_i (cnt_inc[g]),
      .cnt_o (cnt_val[g])
    );
  end

  assign cycles_o       = cnt_val[CNT_CYC];
  assign load_stall_o   = cnt_val[CNT_LDS];
  assign branch_stall_o = cnt_val[CNT_BRS];
  assign taken_o        = cnt_val[CNT_TKN];
  assign untaken_o      = cnt_val[CNT_UNT];
endmodule

// File: rtl/stall_tracker_chk.sv
module stall_tracker_chk #(
  parameter int REG_W  = 4,
  parameter int BASE_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              valid_i,
  input logic              last_i,
  input logic              is_branch_i,
  input logic              taken_i,
  input logic [BASE_W-1:0] base_cyc_i,
  input logic              grp_valid_o,
  input logic [BASE_W+1:0] grp_cycles_o,
  input logic [CNT_W-1:0]  cycles_o,
  input logic [CNT_W-1:0]  load_stall_o,
  input logic [CNT_W-1:0]  branch_stall_o,
  input logic [CNT_W-1:0]  taken_o,
  input logic [CNT_W-1:0]  untaken_o
);
  a_r11_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cycles_o == '0 && load_stall_o == '0 && branch_stall_o == '0 &&
                 taken_o == '0 && untaken_o == '0));

  a_r7_grp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> grp_valid_o);

  a_r7_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && last_i) |=> !grp_valid_o);

  a_r8_cost_covers_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> grp_cycles_o >= (BASE_W+2)'($past(base_cyc_i)));

  a_r9_cycles_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !(valid_i && last_i)) |=> $stable(cycles_o));

  a_r6_brstall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !(valid_i && is_branch_i && taken_i)) |=> $stable(branch_stall_o));

  a_r6_untaken_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_branch_i && !taken_i && !clear_i && untaken_o != '1)
      |=> untaken_o == $past(untaken_o) + CNT_W'(1));

  a_r10_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (cycles_o >= $past(cycles_o) && load_stall_o >= $past(load_stall_o) &&
                  taken_o >= $past(taken_o)));
endmodule

bind stall_tracker stall_tracker_chk #(.REG_W(REG_W), .BASE_W(BASE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clear_i       (clear_i),
  .valid_i       (valid_i),
  .last_i        (last_i),
  .is_branch_i   (is_branch_i),
  .taken_i       (taken_i),
  .base_cyc_i    (base_cyc_i),
  .grp_valid_o   (grp_valid_o),
  .grp_cycles_o  (grp_cycles_o),
  .cycles_o      (cycles_o),
  .load_stall_o  (load_stall_o),
  .branch_stall_o(branch_stall_o),
  .taken_o       (taken_o),
  .untaken_o     (untaken_o)
);

// File: tb/stall_tracker_test.sv
module stall_tracker_test;
  localparam int SW = 6;

  logic       clk = 0, rst_ni = 0, clear = 0, valid = 0, first = 0, last = 0;
  logic [3:0] sa = 0, sb = 0, dst = 0;
  logic       av = 0, bv = 0, ld = 0, br = 0, tk = 0;
  logic [7:0] base = 0;

  logic        gv, s_gv;
  logic [9:0]  gc, s_gc;
  logic [31:0] cyc, lds, brs, tkn, unt;
  logic [SW-1:0] s_cyc, s_lds, s_brs, s_tkn, s_unt;

  int nchk = 0, nfail = 0;
  string cur_req = "R1";

  int pend = 0, act = 0, held = 0, e_gc = 0;
  bit e_gv = 0;
  longint r_cyc = 0, r_ls = 0, r_bs = 0, r_tk = 0, r_ut = 0;

  always #2 clk = ~clk;

  stall_tracker uut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear), .valid_i(valid), .first_i(first), .last_i(last),
    .src_a_i(sa), .src_a_vld_i(av), .src_b_i(sb), .src_b_vld_i(bv), .is_load_i(ld),
    .load_dst_i(dst), .is_branch_i(br), .taken_i(tk), .base_cyc_i(base),
    .grp_valid_o(gv), .grp_cycles_o(gc), .cycles_o(cyc), .load_stall_o(lds),
    .branch_stall_o(brs), .taken_o(tkn), .untaken_o(unt));

  stall_tracker #(.CNT_W(SW)) sat_uut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear), .valid_i(valid), .first_i(first), .last_i(last),
    .src_a_i(sa), .src_a_vld_i(av), .src_b_i(sb), .src_b_vld_i(bv), .is_load_i(ld),
    .load_dst_i(dst), .is_branch_i(br), .taken_i(tk), .base_cyc_i(base),
    .grp_valid_o(s_gv), .grp_cycles_o(s_gc), .cycles_o(s_cyc), .load_stall_o(s_lds),
    .branch_stall_o(s_brs), .taken_o(s_tkn), .untaken_o(s_unt));

  function automatic longint sat(longint v, int w);
    longint m = (longint'(1) << w) - 1;
    return (v > m) ? m : v;
  endfunction

  task automatic chk(string what, longint a, longint e);
    nchk++;
    if (a != e) begin
      nfail++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, a, e);
    end
  endtask

  task automatic check_outputs();
    chk("grp_valid", longint'(gv), longint'(e_gv));
    chk("sat grp_valid", longint'(s_gv), longint'(e_gv));
    if (e_gv) begin
      chk("grp_cycles", longint'(gc), longint'(e_gc));
      chk("sat grp_cycles", longint'(s_gc), longint'(e_gc));
    end
    chk("cycles", longint'(cyc), sat(r_cyc, 32));
    chk("load_stall", longint'(lds), sat(r_ls, 32));
    chk("branch_stall", longint'(brs), sat(r_bs, 32));
    chk("taken", longint'(tkn), sat(r_tk, 32));
    chk("untaken", longint'(unt), sat(r_ut, 32));
    chk("R10 sat cycles", longint'(s_cyc), sat(r_cyc, SW));
    chk("R10 sat load_stall", longint'(s_lds), sat(r_ls, SW));
    chk("R10 sat branch_stall", longint'(s_brs), sat(r_bs, SW));
    chk("R10 sat taken", longint'(s_tkn), sat(r_tk, SW));
    chk("R10 sat untaken", longint'(s_unt), sat(r_ut, SW));
  endtask

  task automatic issue(bit v, bit f, bit l, int a, bit avl, int b, bit bvl,
                       bit isl, int d, bit isb, bit t, int bc, bit clr);
    int ha, hb, ls, bs, cost, hm, g;
    @(negedge clk);
    check_outputs();
    valid = v; first = f; last = l; sa = 4'(a); av = avl; sb = 4'(b); bv = bvl;
    ld = isl; dst = 4'(d); br = isb; tk = t; base = 8'(bc); clear = clr;
    e_gv = 0;
    if (v) begin
      ha = (avl && ((act >> a) & 1) != 0) ? 1 : 0;
      hb = (bvl && !(isl || isb) && ((act >> b) & 1) != 0) ? 1 : 0;
      ls = 2 * (ha + hb);
      bs = (isb && t) ? 2 : 0;
      cost = bc + ls + bs;
      pend = (f ? 0 : pend) | (isl ? (1 << d) : 0);
      act = pend;
      hm = f ? 0 : held;
      g = (hm > cost) ? hm : cost;
      if (l) begin e_gv = 1; e_gc = g; r_cyc += g; end
      else held = g;
      r_ls += ls; r_bs += bs;
      if (isb) begin if (t) r_tk++; else r_ut++; end
    end
    if (clr) begin r_cyc = 0; r_ls = 0; r_bs = 0; r_tk = 0; r_ut = 0; end
  endtask

  // single instruction group
  task automatic one(int a, bit avl, int b, bit bvl, bit isl, int d, bit isb, bit t, int bc);
    issue(1, 1, 1, a, avl, b, bvl, isl, d, isb, t, bc, 0);
  endtask

  task automatic idle();
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1: reset state
    cur_req = "R1";
    idle();

    cur_req = "R7";
    one(0, 0, 0, 0, 0, 0, 0, 0, 1);
    one(0, 0, 0, 0, 0, 0, 0, 0, 3);
    idle();

    cur_req = "R2";
    one(0, 0, 0, 0, 1, 5, 0, 0, 1);
    one(5, 1, 2, 1, 0, 0, 0, 0, 1);   // one hit: +2
    one(0, 0, 0, 0, 1, 5, 0, 0, 1);
    one(5, 1, 5, 1, 0, 0, 0, 0, 1);   // both hit: +4
    idle();

    cur_req = "R3";
    one(0, 0, 0, 0, 1, 3, 0, 0, 1);
    one(7, 1, 0, 0, 0, 0, 0, 0, 1);   // clears visibility
    one(3, 1, 0, 0, 0, 0, 0, 0, 1);   // no stall
    issue(1, 1, 0, 0, 0, 0, 0, 1, 9, 0, 0, 1, 0);
    issue(1, 0, 1, 9, 1, 0, 0, 0, 0, 0, 0, 1, 0); // in-group hit
    issue(1, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 1, 0);
    issue(1, 0, 1, 0, 0, 0, 0, 1, 2, 0, 0, 1, 0);
    one(1, 1, 2, 1, 0, 0, 0, 0, 1);   // both pair loads visible
    idle();

    cur_req = "R4";
    one(0, 0, 0, 0, 1, 4, 0, 0, 1);
    one(0, 0, 4, 1, 1, 6, 0, 0, 1);   // load ignores src_b
    one(0, 0, 0, 0, 1, 4, 0, 0, 1);
    one(0, 0, 4, 1, 0, 0, 1, 0, 1);   // branch ignores src_b
    one(0, 0, 0, 0, 1, 4, 0, 0, 1);
    one(0, 0, 4, 1, 0, 0, 0, 0, 1);   // compare/store: src_b checked
    idle();

    cur_req = "R5";
    one(0, 0, 0, 0, 1, 8, 0, 0, 1);
    one(8, 0, 8, 0, 0, 0, 0, 0, 2);
    idle();

    cur_req = "R6";
    one(0, 0, 0, 0, 0, 0, 1, 1, 1);
    one(0, 0, 0, 0, 0, 0, 1, 0, 1);
    one(0, 0, 0, 0, 0, 0, 0, 1, 1);   // taken without branch
    idle();

    cur_req = "R8";
    issue(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0);
    issue(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 5, 0);
    issue(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6, 0);
    issue(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0);
    issue(1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2, 0);
    issue(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0);
    idle();

    cur_req = "R9";
    issue(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4, 0);
    idle();
    idle();
    issue(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle();

    cur_req = "R10";
    for (int i = 0; i < 40; i++) one(0, 0, 0, 0, 0, 0, 1, (i % 3) != 0, 1);
    idle();

    cur_req = "R11";
    issue(1, 1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 7, 1);  // clear wins over increment
    idle();
    one(0, 0, 0, 0, 1, 2, 0, 0, 1);
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    one(2, 1, 0, 0, 0, 0, 0, 0, 1);  // mask survives clear
    idle();

    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      bit pair = ($urandom % 3) == 0;
      int k = $urandom % 4;
      issue(1, 1, !pair, $urandom % 16, $urandom % 2, $urandom % 16, $urandom % 2,
            k == 0, $urandom % 16, k == 1, $urandom % 2, $urandom % 8, ($urandom % 97) == 0);
      if (pair)
        issue(1, 0, 1, $urandom % 16, $urandom % 2, $urandom % 16, $urandom % 2,
              k == 2, $urandom % 16, k == 3, $urandom % 2, $urandom % 8, 0);
      if (($urandom % 5) == 0) idle();
    end
    idle();
    idle();

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule